// File: doc/BRIEF.md
# Memory-Mapped Character Output Port

This block sits between a processor bus and a character display sink. Software first reads a status word to learn whether the port is free. It then stores a character into a data word. The port presents that character to the sink with a valid signal and holds it until the sink reports that it has consumed it. The port then becomes free again.

A store to the data word while the port is still busy is dropped without any effect. Software may set an interrupt-enable bit in the status word. An interrupt request is then raised whenever the port is free, so the processor can service the port instead of polling it. Reads have no side effects and return zero outside the two decoded addresses.

Top module: `chr_out_port`

## Requirements
- R1: The status word is decoded only at address 0xFE04 and the data word only at 0xFE06. A read at any other address, or with the read strobe low, returns 0. A write at any other address changes nothing.
- R2: After reset the port is free, interrupt enable is 0, `sink_valid` is 0, and a data-word read returns 0.
- R3: A status read returns the free (ready) flag in bit 15, interrupt enable in bit 14, and zeros in bits 13:0.
- R4: A data write while the port is free makes it busy on the next cycle. From then on the status read shows bit 15 = 0, `sink_valid` is 1, and `sink_char` equals write data bits 7:0.
- R5: A data write while the port is busy is ignored. `sink_char`, `sink_valid` and the stored character are unchanged.
- R6: `sink_valid` stays high with a stable `sink_char` until `sink_done` is sampled high. The cycle after that, `sink_valid` is 0 and the port is free. A `sink_done` pulse while the port is idle has no effect.
- R7: A status write loads interrupt enable from write data bit 14. Bit 15 and the other bits of that write are discarded.
- R8: `irq` is high exactly when the port is free and interrupt enable is 1. It is never high while `sink_valid` is high.
- R9: A data read returns the last accepted character in bits 7:0 with bits 15:8 zero. Write data bits 15:8 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| sink_char | output | 8 | Character offered to the display sink |
| sink_valid | output | 1 | Character is valid and waiting |
| sink_done | input | 1 | Sink has consumed the character |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the main paths:
- a single write-then-consume round trip;
- back-to-back writes, where the second must be dropped while the port is busy;
- writes with nonzero upper data bits;
- stray `sink_done` pulses while idle;
- toggling interrupt enable, including attempts to write the ready bit.

A seeded random phase then mixes reads and writes at both decoded addresses and at random addresses with random done pulses. This separates a port that accepts characters only when free from one that overwrites a pending character. It also exposes an enable or ready flag that leaks into or is disturbed by unrelated accesses.

// File: rtl/chr_out_pkg.sv
package chr_out_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06;
  localparam int RDY_BIT = 15;
  localparam int IE_BIT  = 14;
endpackage

// File: rtl/chr_out_decode.sv
module chr_out_decode
  import chr_out_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] STAT_A = STAT_ADDR,
  parameter logic [AW-1:0] DATA_A = DATA_ADDR
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          stat_rd,
  output logic          stat_wr,
  output logic          data_rd,
  output logic          data_wr
);
  logic stat_hit, data_hit;

  always_comb begin
    stat_hit = (addr == STAT_A);
    data_hit = (addr == DATA_A);
    stat_rd  = rd & stat_hit;
    stat_wr  = wr & stat_hit;
    data_rd  = rd & data_hit;
    data_wr  = wr & data_hit;
  end
endmodule

// File: rtl/chr_out_ctrl.sv
module chr_out_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic ie_in,
  output logic ie
);
  logic ie_d, ie_en;

  always_comb begin
    ie_en = stat_wr;
    ie_d  = ie_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie <= 1'b0;
    else if (ie_en) ie <= ie_d;
  end
endmodule

// File: rtl/chr_out_xmit.sv
module chr_out_xmit
  import chr_out_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [CW-1:0] wchar,
  input  logic          done,
  output logic          busy,
  output logic [CW-1:0] char_q
);
  logic          busy_d;
  logic          load_en;
  logic [CW-1:0] char_d;

  always_comb begin
    load_en = data_wr & ~busy;
    char_d  = wchar;
    busy_d  = busy;
    if (load_en)          busy_d = 1'b1;
    else if (busy & done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (load_en) char_q <= char_d;
  end
endmodule

// File: rtl/chr_out_port.sv
module chr_out_port
  import chr_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] sink_char,
  output logic              sink_valid,
  input  logic              sink_done,
  output logic              irq
);
  logic stat_rd, stat_wr, data_rd, data_wr;
  logic busy, ie, ready_w;
  logic [CHAR_W-1:0] char_q;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1:IE_BIT+1], bus_wdata[IE_BIT-1:CHAR_W]};

  chr_out_decode u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .stat_rd(stat_rd), .stat_wr(stat_wr),
    .data_rd(data_rd), .data_wr(data_wr)
  );

  chr_out_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .stat_wr(stat_wr), .ie_in(bus_wdata[IE_BIT]), .ie(ie)
  );

  chr_out_xmit u_xmit (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .wchar(bus_wdata[CHAR_W-1:0]),
    .done(sink_done), .busy(busy), .char_q(char_q)
  );

  always_comb begin
    ready_w    = ~busy;
    sink_valid = busy;
    sink_char  = char_q;
    irq        = ready_w & ie;
    bus_rdata  = '0;
    if (stat_rd) begin
      bus_rdata[RDY_BIT] = ready_w;
      bus_rdata[IE_BIT]  = ie;
    end else if (data_rd) begin
      bus_rdata[CHAR_W-1:0] = char_q;
    end
  end
endmodule

// File: rtl/chr_out_port_chk.sv
module chr_out_port_chk
  import chr_out_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CHAR_W-1:0] sink_char,
  input logic              sink_valid,
  input logic              sink_done,
  input logic              irq,
  input logic              ready,
  input logic              ie
);
  // R4
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR && ready) |=>
      (sink_valid && !ready && sink_char == $past(bus_wdata[CHAR_W-1:0])));

  // R5
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR && !ready && !sink_done) |=>
      ($stable(sink_char) && sink_valid));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && !sink_done) |=> (sink_valid && $stable(sink_char)));

  // R6
  valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && sink_done) |=> (!sink_valid && ready));

  // R7
  ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STAT_ADDR) |=> (ie == $past(bus_wdata[IE_BIT])));

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !sink_valid);
endmodule

bind chr_out_port chr_out_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .sink_char(sink_char), .sink_valid(sink_valid),
  .sink_done(sink_done), .irq(irq), .ready(ready_w), .ie(ie)
);

// File: tb/chr_out_port_bench.sv
module chr_out_port_bench;
  logic        clk, rst_n;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, sink_done, sink_valid, irq;
  logic [7:0]  sink_char;

  int checks = 0;
  int failures = 0;

  // Reference state kept by the bench
  logic       m_ready, m_ie;
  logic [7:0] m_char;

  localparam logic [15:0] A_STAT = 16'hFE04;
  localparam logic [15:0] A_DATA = 16'hFE06;

  chr_out_port u_chr_out_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sink_char(sink_char), .sink_valid(sink_valid), .sink_done(sink_done),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] exp_rdata(logic rd, logic [15:0] a);
    if (!rd)         return 16'h0;
    if (a == A_STAT) return {m_ready, m_ie, 14'h0};
    if (a == A_DATA) return {8'h00, m_char};
    return 16'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare pre-edge outputs, update model at edge.
  task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                      input logic [15:0] wd, input logic dn, input string tag);
    logic [15:0] er;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; sink_done = dn;
    #1;
    er = exp_rdata(rd, a);
    chk(bus_rdata == er, {tag, " rdata R1/R3/R9"}, bus_rdata, er);
    chk(sink_valid == !m_ready, {tag, " valid R6"}, {15'h0, sink_valid}, {15'h0, !m_ready});
    chk(irq == (m_ready & m_ie), {tag, " irq R8"}, {15'h0, irq}, {15'h0, m_ready & m_ie});
    if (!m_ready)
      chk(sink_char == m_char, {tag, " char R4/R5"}, {8'h0, sink_char}, {8'h0, m_char});
    @(posedge clk);
    if (wr && a == A_STAT) m_ie = wd[14];
    if (wr && a == A_DATA && m_ready) begin
      m_char = wd[7:0];
      m_ready = 1'b0;
    end else if (dn && !m_ready) begin
      m_ready = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int unsigned seed;
    int unsigned r;
    seed = 32'd1234;
    r = $urandom(seed);
    m_ready = 1'b1; m_ie = 1'b0; m_char = 8'h00;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; sink_done = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R2 reset state
    step(1, 0, A_STAT, 16'h0, 0, "R2 status after reset");
    step(1, 0, A_DATA, 16'h0, 0, "R2 data after reset");
    // R4 accept with upper bits set (R9 discard)
    step(0, 1, A_DATA, 16'hA541, 0, "R4 first write");
    step(1, 0, A_STAT, 16'h0, 0, "R4 busy status");
    // R5 busy write dropped
    step(0, 1, A_DATA, 16'h0042, 0, "R5 busy write");
    step(1, 0, A_DATA, 16'h0, 0, "R5 R9 data kept");
    // R6 done releases
    step(0, 0, 16'h0, 16'h0, 1, "R6 done");
    step(1, 0, A_STAT, 16'h0, 0, "R6 ready again");
    // R6 stray done while idle
    step(0, 0, 16'h0, 16'h0, 1, "R6 stray done");
    step(1, 0, A_STAT, 16'h0, 0, "R6 idle after stray");
    // R7 enable, ready bit write ignored; R8 irq
    step(0, 1, A_STAT, 16'h4000, 0, "R7 set ie");
    step(1, 0, A_STAT, 16'h0, 0, "R7 R8 ie visible");
    step(0, 1, A_DATA, 16'h007A, 0, "R8 irq drops when busy");
    step(0, 1, A_STAT, 16'h8000, 0, "R7 write ready bit ignored, ie cleared");
    step(1, 0, A_STAT, 16'h0, 0, "R7 still busy");
    step(0, 0, 16'h0, 16'h0, 1, "R6 done 2");
    // R1 off-address accesses
    step(0, 1, 16'hFE05, 16'hFFFF, 0, "R1 write near addr");
    step(1, 0, 16'hFE02, 16'h0, 0, "R1 read other addr");
    step(0, 1, 16'h0006, 16'h4033, 0, "R1 write other addr");
    step(1, 0, A_STAT, 16'h0, 0, "R1 state untouched");
    step(1, 0, A_DATA, 16'h0, 0, "R1 R9 char untouched");

    // Constrained random phase
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      case (r[1:0])
        2'd0: a = A_STAT;
        2'd1, 2'd2: a = A_DATA;
        default: a = 16'($urandom);
      endcase
      step(r[2], r[3] & r[4], a, 16'($urandom), r[5] & r[6], "random R4/R5/R6/R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule